// File: doc/BRIEF.md
# Memory-Op Scheduler with Overflow Dispatch Queue

This block holds memory operations (loads and stores) between rename and the address units of an out-of-order core. Every accepted op first lands in a small first-in first-out dispatch queue. From there the head op moves into the scheduler whenever a scheduler slot is free, at most one op per cycle. An op stays in the scheduler until all of its source operands have been woken up. It then issues, oldest first, provided the load queue or store queue it needs has a free entry.

The dispatch queue lets the frontend keep sending memory ops while the scheduler is full. Ops bound for the integer and floating-point queues are not affected. When the dispatch queue and the scheduler are both full and another memory op is offered, the block raises a global stall. The surrounding dispatch logic uses that stall to stop sending ops to every queue until room opens. The default sizes are 48 scheduler slots and 10 dispatch-queue slots; a small core would use 18 and 6.

Top module: `mem_op_sched`

## Requirements
- R1: After reset both structures are empty: `dispReady` is 1, `issueValid` is 0 and `stallAll` is 0.
- R2: An op accepted at clock edge k enters the dispatch queue. It moves into the scheduler at edge k+1 if a slot is free at the start of that cycle. If all its sources are ready, it can appear on `issueValid` in the cycle after edge k+1. Ops leave the dispatch queue in acceptance order, at most one per cycle.
- R3: `dispReady` is 1 whenever the dispatch queue has room, even while the scheduler is full. It is 0 only when the dispatch queue and the scheduler are both full.
- R4: `stallAll` is 1 exactly when `dispValid` is 1 while both structures are full. It is 0 whenever `dispValid` is 0.
- R5: Source k of an op is ready if `dispSrcRdy[k]` was 1 at dispatch, or if a wakeup lane w (`wakeValid[w]`=1, tag at `wakeTag[w*TAG_W +: TAG_W]`) matches the source tag (`dispSrcTag[k*TAG_W +: TAG_W]`). The match counts while the op is being accepted, while it waits in the dispatch queue, while it moves into the scheduler, or while it sits in the scheduler. An op issues only when all its sources are ready. A wakeup takes effect for issue in the cycle after its edge.
- R6: At most one op issues per cycle, and it is the oldest eligible op in the scheduler, where age follows acceptance order.
- R7: A load (`dispIsStore`=0) is not eligible while `ldqFree` is 0, and a store (`dispIsStore`=1) is not eligible while `stqFree` is 0. A younger op of the other kind may issue past it. `issueIsStore` reports the kind of the issued op.
- R8: Without any issue, SCHED_DEPTH + DQ_DEPTH ops are accepted. The next offered op is refused and raises `stallAll`.
- R9: With SCHED_DEPTH-1 blocked ops in the scheduler, an independent op still enters the last slot and issues.
- R10: An issued op leaves the scheduler at the issue edge, frees its slot and is never issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | A memory op is offered |
| dispReady | output | 1 | Offered op is accepted this cycle |
| dispId | input | ID_W | Op identifier carried to issue |
| dispIsStore | input | 1 | 1 = store, 0 = load |
| dispSrcTag | input | NUM_SRC*TAG_W | Source tags, slot k at bits k*TAG_W |
| dispSrcRdy | input | NUM_SRC | Source k already available at dispatch |
| wakeValid | input | WAKE_N | Wakeup lane valid |
| wakeTag | input | WAKE_N*TAG_W | Wakeup tags, lane w at bits w*TAG_W |
| ldqFree | input | 1 | Load queue has a free entry |
| stqFree | input | 1 | Store queue has a free entry |
| issueValid | output | 1 | An op issues this cycle |
| issueId | output | ID_W | Identifier of the issuing op |
| issueIsStore | output | 1 | Kind of the issuing op |
| stallAll | output | 1 | Global dispatch stall |

## Verification
The assertions assume that every input has a defined value in each cycle after reset. They also assume `ldqFree` and `stqFree` reflect the queue state in the same cycle in which the issue decision is taken. The stimulus changes all inputs only on the falling clock edge and always drives them from defined values. It keeps offering ops while `dispReady` is low, so the refused-op path and the stall are exercised without breaking the handshake.

// File: rtl/mem_sched_pkg.sv
package mem_sched_pkg;
  parameter int ID_W    = 8;
  parameter int TAG_W   = 6;
  parameter int NUM_SRC = 2;

  typedef struct packed {
    logic [ID_W-1:0]                 id;
    logic                            isStore;
    logic [NUM_SRC-1:0][TAG_W-1:0]   tag;
    logic [NUM_SRC-1:0]              rdy;
  } memOp_t;

  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic push;
    logic pop;
    logic issue;
  } schedStrobe_t;
endpackage

// File: rtl/mem_sched_ctl.sv
module mem_sched_ctl
  import mem_sched_pkg::*;
#(
  parameter int SCHED_DEPTH = 48,
  parameter int DQ_DEPTH    = 10,
  localparam int DQ_CNT_W   = $clog2(DQ_DEPTH + 1),
  localparam int DQ_PTR_W   = $clog2(DQ_DEPTH),
  localparam int SCH_CNT_W  = $clog2(SCHED_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    dispValid,
  input  logic [SCHED_DEPTH-1:0]  rdyVec,
  input  logic [SCHED_DEPTH-1:0]  isStVec,
  input  logic                    ldqFree,
  input  logic                    stqFree,
  output schedStrobe_t            strb,
  output logic [SCHED_DEPTH-1:0]  issueSel,
  output logic [DQ_PTR_W-1:0]     dqWrPtr,
  output logic [DQ_PTR_W-1:0]     dqRdPtr,
  output logic [SCH_CNT_W-1:0]    insIdx,
  output logic [DQ_CNT_W-1:0]     dqCount,
  output logic [SCH_CNT_W-1:0]    schedCount,
  output logic                    dispReady,
  output logic                    stallAll,
  output logic                    issueValid
);
  logic dqFull, schedFull;
  logic [SCHED_DEPTH-1:0] elig;

  assign dqFull    = (dqCount == DQ_CNT_W'(DQ_DEPTH));
  assign schedFull = (schedCount == SCH_CNT_W'(SCHED_DEPTH));

  // Free slot is judged on the count at the start of the cycle.
  assign strb.pop   = (dqCount != '0) && !schedFull;
  assign dispReady  = !dqFull || !schedFull;
  assign strb.push  = dispValid && dispReady;
  assign stallAll   = dispValid && !dispReady;

  for (genvar i = 0; i < SCHED_DEPTH; i++) begin : g_elig
    assign elig[i] = (SCH_CNT_W'(i) < schedCount) && rdyVec[i]
                   && (isStVec[i] ? stqFree : ldqFree);
  end

  // Lowest index is oldest in the collapsing array.
  assign issueSel   = elig & (~elig + SCHED_DEPTH'(1));
  assign strb.issue = |elig;
  assign issueValid = strb.issue;
  assign insIdx     = schedCount - SCH_CNT_W'(strb.issue);

  function automatic logic [DQ_PTR_W-1:0] bumpPtr(logic [DQ_PTR_W-1:0] p);
    return (p == DQ_PTR_W'(DQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqCount    <= '0;
      schedCount <= '0;
      dqWrPtr    <= '0;
      dqRdPtr    <= '0;
    end else begin
      dqCount    <= dqCount + DQ_CNT_W'(strb.push) - DQ_CNT_W'(strb.pop);
      schedCount <= schedCount + SCH_CNT_W'(strb.pop) - SCH_CNT_W'(strb.issue);
      if (strb.push) dqWrPtr <= bumpPtr(dqWrPtr);
      if (strb.pop)  dqRdPtr <= bumpPtr(dqRdPtr);
    end
  end
endmodule

// File: rtl/mem_sched_dp.sv
module mem_sched_dp
  import mem_sched_pkg::*;
#(
  parameter int SCHED_DEPTH = 48,
  parameter int DQ_DEPTH    = 10,
  parameter int WAKE_N      = 2,
  localparam int DQ_PTR_W   = $clog2(DQ_DEPTH),
  localparam int SCH_CNT_W  = $clog2(SCHED_DEPTH + 1)
) (
  input  logic                     clk,
  input  memOp_t                   dispOp,
  input  logic [WAKE_N-1:0]        wakeValid,
  input  logic [WAKE_N*TAG_W-1:0]  wakeTag,
  input  schedStrobe_t             strb,
  input  logic [SCHED_DEPTH-1:0]   issueSel,
  input  logic [DQ_PTR_W-1:0]      dqWrPtr,
  input  logic [DQ_PTR_W-1:0]      dqRdPtr,
  input  logic [SCH_CNT_W-1:0]     insIdx,
  output logic [SCHED_DEPTH-1:0]   rdyVec,
  output logic [SCHED_DEPTH-1:0]   isStVec,
  output logic [ID_W-1:0]          issueId,
  output logic                     issueIsStore
);
  memOp_t dq       [DQ_DEPTH];
  memOp_t sched    [SCHED_DEPTH];
  memOp_t shSrc    [SCHED_DEPTH];
  memOp_t schedNxt [SCHED_DEPTH];
  logic [SCHED_DEPTH-1:0] shiftVec;

  function automatic memOp_t wakeOp(memOp_t op);
    memOp_t r = op;
    for (int s = 0; s < NUM_SRC; s++)
      for (int w = 0; w < WAKE_N; w++)
        if (wakeValid[w] && (wakeTag[w*TAG_W +: TAG_W] == op.tag[s]))
          r.rdy[s] = 1'b1;
    return r;
  endfunction

  // shiftVec[i]: entry i is at or above the issuing slot.
  assign shiftVec[0] = issueSel[0];
  for (genvar i = 1; i < SCHED_DEPTH; i++) begin : g_pref
    assign shiftVec[i] = shiftVec[i-1] | issueSel[i];
  end

  for (genvar i = 0; i < SCHED_DEPTH; i++) begin : g_slot
    if (i == SCHED_DEPTH - 1) begin : g_top
      assign shSrc[i] = sched[i];
    end else begin : g_mid
      assign shSrc[i] = (strb.issue && shiftVec[i]) ? sched[i+1] : sched[i];
    end
    assign schedNxt[i] = (strb.pop && (insIdx == SCH_CNT_W'(i)))
                         ? wakeOp(dq[dqRdPtr]) : wakeOp(shSrc[i]);
    assign rdyVec[i]   = &sched[i].rdy;
    assign isStVec[i]  = sched[i].isStore;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DQ_DEPTH; i++) dq[i] <= wakeOp(dq[i]);
    if (strb.push) dq[dqWrPtr] <= wakeOp(dispOp);
    for (int i = 0; i < SCHED_DEPTH; i++) sched[i] <= schedNxt[i];
  end

  always_comb begin
    issueId      = '0;
    issueIsStore = 1'b0;
    for (int i = 0; i < SCHED_DEPTH; i++) begin
      issueId      = issueId | (sched[i].id & {ID_W{issueSel[i]}});
      issueIsStore = issueIsStore | (sched[i].isStore & issueSel[i]);
    end
  end
endmodule

// File: rtl/mem_op_sched.sv
module mem_op_sched
  import mem_sched_pkg::*;
#(
  parameter int SCHED_DEPTH = 48,
  parameter int DQ_DEPTH    = 10,
  parameter int WAKE_N      = 2,
  localparam int DQ_CNT_W   = $clog2(DQ_DEPTH + 1),
  localparam int DQ_PTR_W   = $clog2(DQ_DEPTH),
  localparam int SCH_CNT_W  = $clog2(SCHED_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      dispValid,
  output logic                      dispReady,
  input  logic [ID_W-1:0]           dispId,
  input  logic                      dispIsStore,
  input  logic [NUM_SRC*TAG_W-1:0]  dispSrcTag,
  input  logic [NUM_SRC-1:0]        dispSrcRdy,
  input  logic [WAKE_N-1:0]         wakeValid,
  input  logic [WAKE_N*TAG_W-1:0]   wakeTag,
  input  logic                      ldqFree,
  input  logic                      stqFree,
  output logic                      issueValid,
  output logic [ID_W-1:0]           issueId,
  output logic                      issueIsStore,
  output logic                      stallAll
);
  memOp_t                  dispOp;
  schedStrobe_t            strb;
  logic [SCHED_DEPTH-1:0]  rdyVec, isStVec, issueSel;
  logic [DQ_PTR_W-1:0]     dqWrPtr, dqRdPtr;
  logic [SCH_CNT_W-1:0]    insIdx, schedCount;
  logic [DQ_CNT_W-1:0]     dqCount;

  assign dispOp.id      = dispId;
  assign dispOp.isStore = dispIsStore;
  assign dispOp.tag     = dispSrcTag;
  assign dispOp.rdy     = dispSrcRdy;

  mem_sched_ctl #(.SCHED_DEPTH(SCHED_DEPTH), .DQ_DEPTH(DQ_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid),
    .rdyVec(rdyVec), .isStVec(isStVec), .ldqFree(ldqFree), .stqFree(stqFree),
    .strb(strb), .issueSel(issueSel), .dqWrPtr(dqWrPtr), .dqRdPtr(dqRdPtr),
    .insIdx(insIdx), .dqCount(dqCount), .schedCount(schedCount),
    .dispReady(dispReady), .stallAll(stallAll), .issueValid(issueValid)
  );

  mem_sched_dp #(.SCHED_DEPTH(SCHED_DEPTH), .DQ_DEPTH(DQ_DEPTH), .WAKE_N(WAKE_N)) u_dp (
    .clk(clk), .dispOp(dispOp), .wakeValid(wakeValid), .wakeTag(wakeTag),
    .strb(strb), .issueSel(issueSel), .dqWrPtr(dqWrPtr), .dqRdPtr(dqRdPtr),
    .insIdx(insIdx), .rdyVec(rdyVec), .isStVec(isStVec),
    .issueId(issueId), .issueIsStore(issueIsStore)
  );
endmodule

// File: rtl/mem_sched_chk.sv
module mem_sched_chk #(
  parameter int SCHED_DEPTH = 48,
  parameter int DQ_DEPTH    = 10,
  localparam int DQ_CNT_W   = $clog2(DQ_DEPTH + 1),
  localparam int SCH_CNT_W  = $clog2(SCHED_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dispValid,
  input logic                 dispReady,
  input logic                 stallAll,
  input logic                 issueValid,
  input logic                 issueIsStore,
  input logic                 ldqFree,
  input logic                 stqFree,
  input logic [DQ_CNT_W-1:0]  dqCount,
  input logic [SCH_CNT_W-1:0] schedCount,
  input logic                 popStb
);
  a_r8_dq_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(dqCount) <= DQ_DEPTH);

  a_r8_sched_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(schedCount) <= SCHED_DEPTH);

  a_r3_room_ready: assert property (@(posedge clk) disable iff (!rstN)
    (int'(dqCount) < DQ_DEPTH) |-> dispReady);

  a_r4_stall_full: assert property (@(posedge clk) disable iff (!rstN)
    stallAll |-> (dispValid && int'(dqCount) == DQ_DEPTH
                  && int'(schedCount) == SCHED_DEPTH));

  a_r2_single_move: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (int'(schedCount) <= int'($past(schedCount)) + 1));

  a_r7_load_gate: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueIsStore) |-> ldqFree);

  a_r7_store_gate: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueIsStore) |-> stqFree);

  a_r10_slot_freed: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !popStb) |=> (int'(schedCount) == int'($past(schedCount)) - 1));
endmodule

bind mem_op_sched mem_sched_chk #(.SCHED_DEPTH(SCHED_DEPTH), .DQ_DEPTH(DQ_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
  .stallAll(stallAll), .issueValid(issueValid), .issueIsStore(issueIsStore),
  .ldqFree(ldqFree), .stqFree(stqFree), .dqCount(dqCount),
  .schedCount(schedCount), .popStb(strb.pop)
);

// File: tb/mem_op_sched_tb.sv
module mem_op_sched_tb;
  localparam int SD = 48;
  localparam int DQ = 10;

  typedef struct packed {
    logic [7:0] id;
    logic       st;
    logic [5:0] t1;
    logic [5:0] t0;
    logic       r1;
    logic       r0;
  } mop_t;

  logic clk = 1'b0;
  logic rstN;
  logic dispValid, dispReady, dispIsStore;
  logic [7:0]  dispId;
  logic [11:0] dispSrcTag;
  logic [1:0]  dispSrcRdy;
  logic [1:0]  wakeValid;
  logic [11:0] wakeTag;
  logic ldqFree, stqFree;
  logic issueValid, issueIsStore, stallAll;
  logic [7:0] issueId;

  int checks = 0;
  int errors = 0;
  int nextId = 0;
  mop_t mdq[$];
  mop_t msc[$];

  always #4 clk = ~clk;

  mem_op_sched u_dut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
    .dispId(dispId), .dispIsStore(dispIsStore), .dispSrcTag(dispSrcTag),
    .dispSrcRdy(dispSrcRdy), .wakeValid(wakeValid), .wakeTag(wakeTag),
    .ldqFree(ldqFree), .stqFree(stqFree), .issueValid(issueValid),
    .issueId(issueId), .issueIsStore(issueIsStore), .stallAll(stallAll)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic mop_t mwake(mop_t op);
    mop_t r = op;
    for (int w = 0; w < 2; w++) begin
      if (wakeValid[w] && wakeTag[w*6 +: 6] == op.t0) r.r0 = 1'b1;
      if (wakeValid[w] && wakeTag[w*6 +: 6] == op.t1) r.r1 = 1'b1;
    end
    return r;
  endfunction

  // Compare against the model, advance the model, wait for the next falling edge.
  task automatic step();
    int e;
    bit expRdy, pop, acc;
    mop_t nop;
    #1;
    e = -1;
    for (int i = 0; i < msc.size(); i++)
      if (msc[i].r0 && msc[i].r1 && (msc[i].st ? stqFree : ldqFree)) begin
        e = i;
        break;
      end
    expRdy = (mdq.size() < DQ) || (msc.size() < SD);
    chk(dispReady == expRdy, "R3 dispReady", dispReady, expRdy);
    chk(stallAll == (dispValid && !expRdy), "R4 stallAll", stallAll, dispValid && !expRdy);
    chk(issueValid == (e >= 0), "R6 issueValid", issueValid, e >= 0);
    if (e >= 0) begin
      chk(issueId == msc[e].id, "R6 R10 issueId", issueId, msc[e].id);
      chk(issueIsStore == msc[e].st, "R7 issueIsStore", issueIsStore, msc[e].st);
    end
    pop = (mdq.size() > 0) && (msc.size() < SD);
    acc = dispValid && expRdy;
    if (e >= 0) msc.delete(e);
    foreach (msc[i]) msc[i] = mwake(msc[i]);
    foreach (mdq[i]) mdq[i] = mwake(mdq[i]);
    if (pop) msc.push_back(mdq.pop_front());
    if (acc) begin
      nop = '{id: dispId, st: dispIsStore, t1: dispSrcTag[11:6], t0: dispSrcTag[5:0],
              r1: dispSrcRdy[1], r0: dispSrcRdy[0]};
      mdq.push_back(mwake(nop));
      nextId++;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    dispValid = 1'b0;
    wakeValid = '0;
  endtask

  task automatic offer(bit st, int t0, bit r0, int t1, bit r1);
    dispValid   = 1'b1;
    dispId      = nextId[7:0];
    dispIsStore = st;
    dispSrcTag  = {t1[5:0], t0[5:0]};
    dispSrcRdy  = {r1, r0};
    wakeValid   = '0;
  endtask

  task automatic wake1(int t);
    dispValid = 1'b0;
    wakeValid = 2'b01;
    wakeTag   = {6'd0, t[5:0]};
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idA, idB;
    rstN = 1'b0;
    idle();
    dispId = '0; dispIsStore = 1'b0; dispSrcTag = '0; dispSrcRdy = '0;
    wakeTag = '0; ldqFree = 1'b1; stqFree = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(dispReady == 1'b1, "R1 reset dispReady", dispReady, 1);
    chk(issueValid == 1'b0, "R1 reset issueValid", issueValid, 0);
    chk(stallAll == 1'b0, "R1 reset stallAll", stallAll, 0);
    step();

    // R2: two edges from acceptance to issue visibility.
    idA = nextId;
    offer(1'b0, 1, 1'b1, 2, 1'b1);
    step();
    idle();
    #1 chk(issueValid == 1'b0, "R2 op still in dispatch queue", issueValid, 0);
    step();
    #1 chk(issueValid == 1'b1 && int'(issueId) == (idA & 255), "R2 op issuable", issueId, idA & 255);
    step();

    // R5: blocked until its tag is woken.
    idA = nextId;
    offer(1'b1, 5, 1'b0, 3, 1'b1);
    step();
    idle();
    step(); step();
    #1 chk(issueValid == 1'b0, "R5 waits for operand", issueValid, 0);
    wake1(5);
    step();
    idle();
    #1 chk(issueValid == 1'b1 && int'(issueId) == (idA & 255), "R5 issues after wakeup", issueId, idA & 255);
    step();

    // R7: load held by a full load queue, younger store passes.
    ldqFree = 1'b0;
    idA = nextId;
    offer(1'b0, 1, 1'b1, 1, 1'b1);
    step();
    idB = nextId;
    offer(1'b1, 1, 1'b1, 1, 1'b1);
    step();
    idle();
    step();
    #1 chk(issueValid && issueIsStore && int'(issueId) == (idB & 255), "R7 store passes blocked load", issueId, idB & 255);
    step();
    ldqFree = 1'b1;
    #1 chk(issueValid && !issueIsStore && int'(issueId) == (idA & 255), "R7 load issues once released", issueId, idA & 255);
    step();

    // R8 / R3 / R4: fill both structures with blocked ops.
    for (int i = 0; i < SD + DQ; i++) begin
      offer(1'b0, 9, 1'b0, 1, 1'b1);
      if (i == 50) #1 chk(dispReady == 1'b1, "R3 ready with scheduler full", dispReady, 1);
      step();
    end
    idle();
    repeat (3) step();
    offer(1'b0, 9, 1'b0, 1, 1'b1);
    #1 chk(stallAll == 1'b1 && dispReady == 1'b0, "R8 full raises stall", stallAll, 1);
    step();
    idle();
    #1 chk(stallAll == 1'b0, "R4 no stall without offer", stallAll, 0);
    wake1(9);
    step();
    idle();
    repeat (70) step();
    chk(msc.size() == 0 && mdq.size() == 0, "R10 all drained once each", msc.size() + mdq.size(), 0);

    // R9: one free slot suffices.
    for (int i = 0; i < SD - 1; i++) begin
      offer(1'b1, 11, 1'b0, 1, 1'b1);
      step();
    end
    idle();
    repeat (3) step();
    idA = nextId;
    offer(1'b0, 2, 1'b1, 3, 1'b1);
    step();
    idle();
    step();
    #1 chk(issueValid && int'(issueId) == (idA & 255), "R9 independent op uses last slot", issueId, idA & 255);
    step();
    wake1(11);
    step();
    idle();
    repeat (60) step();

    // Mixed random traffic against the model.
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 9) < 7)
        offer($urandom_range(0, 1) != 0, $urandom_range(0, 15), $urandom_range(0, 1) != 0,
              $urandom_range(0, 15), $urandom_range(0, 1) != 0);
      else
        idle();
      wakeValid = {$urandom_range(0, 9) < 4, $urandom_range(0, 9) < 4};
      wakeTag   = {6'($urandom_range(0, 15)), 6'($urandom_range(0, 15))};
      ldqFree   = $urandom_range(0, 9) < 8;
      stqFree   = $urandom_range(0, 9) < 8;
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule